// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the load-linked reservations that are open against one cache line. A reservation remembers which requester context asked for it and an inclusive byte range that starts at the request address. The table has a fixed number of slots. When it is full, a new reservation displaces the one that has been held longest. The block holds no data, does no tag lookup and runs no coherence protocol. Its only job is to say whether a store-conditional may complete, and to keep the reservation set correct as other traffic reaches the line.

One request arrives per cycle on a valid-qualified bus. It carries an operation code, a context ID, a start address and a byte size. Exactly one cycle later the block returns a response strobe with a pass/fail bit. The block also drives two status outputs at all times: a flag that is high while any reservation is held, and the number of reservations held.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is held: `resv_live` is 0, `resv_count` is 0 and `rsp_valid` is 0.
- R2: Each cycle with `req_valid` high produces `rsp_valid` high in the following cycle and in no other cycle. The `req_kind` encodings are 0 load-linked, 1 store-conditional, 2 ordinary write and 3 invalidate.
- R3: A load-linked records the context together with the range from `req_addr` up to `req_addr + req_size - 1`. Afterwards `resv_live` is 1. When nothing was removed or evicted, `resv_count` is one greater than before.
- R4: Before it records its own entry, a load-linked removes every held reservation whose range overlaps its range, whatever the context of that reservation.
- R5: A store-conditional returns `rsp_ok` = 1 only when a held reservation has the same context and covers the whole request range. Otherwise it returns 0, which includes the case where no reservation is held.
- R6: A successful store-conditional consumes the single matching reservation, taking the newest one first. A repeat of the same store-conditional then fails.
- R7: A store-conditional, whether it passes or fails, removes every overlapping reservation of another context. An overlapping reservation of the same context that does not cover the request stays in place.
- R8: An ordinary write always returns `rsp_ok` = 1. It removes only the overlapping reservations of other contexts. Reservations of the writer's own context, and reservations that do not overlap, stay in place. A write to an empty table changes nothing.
- R9: An invalidate returns `rsp_ok` = 1 and removes all reservations.
- R10: A load-linked that arrives while all DEPTH slots are held and none of them overlaps it evicts the oldest reservation. `resv_count` stays at DEPTH and never exceeds it.
- R11: When `req_addr + req_size - 1` would pass the top of the address space, the range ends at the all-ones address instead of wrapping. A request size of 0 is treated as 1.
- R12: A load-linked always returns `rsp_ok` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 load-linked, 1 store-conditional, 2 write, 3 invalidate |
| req_ctx | input | CTX_W | Requester context ID |
| req_addr | input | ADDR_W | First byte address of the request |
| req_size | input | SIZE_W | Number of bytes in the request |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Store-conditional result; 1 for the other operations |
| resv_live | output | 1 | At least one reservation is held |
| resv_count | output | $clog2(DEPTH+1) | Number of reservations held |

## Verification
Directed sequences try each operation against a reservation of its own context and against one of a foreign context. They cover ranges that are covered, ranges that only partly overlap and ranges that are disjoint. This separates the three range predicates and the context qualifier, which a single-context test cannot tell apart. A fill-then-overflow sequence, followed by store-conditionals to the first and second reservations, shows whether eviction takes the oldest entry. A reservation at the top of the address space shows whether the end of a range clamps or wraps. A long mixed run then sends back-to-back requests from three contexts over a narrow address window, where overlaps are frequent. Every response and the occupancy are compared against a queue model ordered by age.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LL  = 2'd0,
    OP_SC  = 2'd1,
    OP_WR  = 2'd2,
    OP_INV = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_range_cmp.sv
// Range and context comparison between one table entry and the request.
module llsc_range_cmp #(
  parameter int CTX_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic [CTX_W-1:0]  ent_ctx,
  input  logic [ADDR_W-1:0] ent_lo,
  input  logic [ADDR_W-1:0] ent_hi,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [ADDR_W-1:0] req_lo,
  input  logic [ADDR_W-1:0] req_hi,
  output logic              same_ctx,
  output logic              covers,
  output logic              overlaps
);
  assign same_ctx = (ent_ctx == req_ctx);
  // request range lies wholly inside the entry range
  assign covers   = (req_lo >= ent_lo) && (req_hi <= ent_hi);
  // the two ranges share at least one byte
  assign overlaps = (req_lo <= ent_hi) && (req_hi >= ent_lo);
endmodule

// File: rtl/llsc_age_order.sv
// Pairwise age matrix: older_q[i][j] = 1 means slot i was filled before slot j.
module llsc_age_order #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] ins_vec,
  input  logic [DEPTH-1:0] live_vec,
  input  logic [DEPTH-1:0] pick_mask,
  output logic [DEPTH-1:0] oldest_vec,
  output logic [DEPTH-1:0] newest_vec
);
  logic [DEPTH-1:0] older_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (i != j) begin
            if (ins_vec[i])      older_q[i][j] <= 1'b0;
            else if (ins_vec[j]) older_q[i][j] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic old_ok;
      logic new_ok;
      old_ok = 1'b1;
      new_ok = 1'b1;
      for (int j = 0; j < DEPTH; j++) begin
        if (i != j) begin
          old_ok = old_ok & (~live_vec[j]  | older_q[i][j]);
          new_ok = new_ok & (~pick_mask[j] | older_q[j][i]);
        end
      end
      oldest_vec[i] = live_vec[i]  & old_ok;
      newest_vec[i] = pick_mask[i] & new_ok;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int DEPTH  = 4,
  parameter int CTX_W  = 4,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [1:0]                 req_kind,
  input  logic [CTX_W-1:0]           req_ctx,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [SIZE_W-1:0]          req_size,
  output logic                       rsp_valid,
  output logic                       rsp_ok,
  output logic                       resv_live,
  output logic [$clog2(DEPTH+1)-1:0] resv_count
);
  import llsc_pkg::*;

  localparam int CNT_W = $clog2(DEPTH+1);

  // Last byte of a request, clamped at the top of the address space.
  function automatic logic [ADDR_W-1:0] span_high(input logic [ADDR_W-1:0] a,
                                                  input logic [SIZE_W-1:0] s);
    logic [ADDR_W:0] sum;
    logic [ADDR_W:0] ext;
    ext = (s == '0) ? (ADDR_W+1)'(1) : (ADDR_W+1)'(s);
    sum = {1'b0, a} + ext - (ADDR_W+1)'(1);
    return sum[ADDR_W] ? {ADDR_W{1'b1}} : sum[ADDR_W-1:0];
  endfunction

  // One-hot of the lowest set bit.
  function automatic logic [DEPTH-1:0] lowest_one(input logic [DEPTH-1:0] v);
    logic [DEPTH-1:0] r;
    logic             seen;
    r    = '0;
    seen = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (v[i] && !seen) begin
        r[i] = 1'b1;
        seen = 1'b1;
      end
    end
    return r;
  endfunction

  // table storage
  logic [DEPTH-1:0]  valid_q;
  logic [CTX_W-1:0]  ctx_q [DEPTH];
  logic [ADDR_W-1:0] lo_q  [DEPTH];
  logic [ADDR_W-1:0] hi_q  [DEPTH];

  // request decode
  logic [ADDR_W-1:0] rq_lo;
  logic [ADDR_W-1:0] rq_hi;
  logic is_ll, is_sc, is_wr, is_inv;

  assign rq_lo  = req_addr;
  assign rq_hi  = span_high(req_addr, req_size);
  assign is_ll  = req_valid && (req_kind == OP_LL);
  assign is_sc  = req_valid && (req_kind == OP_SC);
  assign is_wr  = req_valid && (req_kind == OP_WR);
  assign is_inv = req_valid && (req_kind == OP_INV);

  // per-entry comparisons
  logic [DEPTH-1:0] same_v, cover_v, over_v;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    llsc_range_cmp #(.CTX_W(CTX_W), .ADDR_W(ADDR_W)) u_cmp (
      .ent_ctx  (ctx_q[g]),
      .ent_lo   (lo_q[g]),
      .ent_hi   (hi_q[g]),
      .req_ctx  (req_ctx),
      .req_lo   (rq_lo),
      .req_hi   (rq_hi),
      .same_ctx (same_v[g]),
      .covers   (cover_v[g]),
      .overlaps (over_v[g])
    );
  end

  // named internal events
  logic [DEPTH-1:0] ll_kill;     // overlapping, any context
  logic [DEPTH-1:0] other_kill;  // overlapping, foreign context
  logic [DEPTH-1:0] sc_match;    // same context and covering
  logic [DEPTH-1:0] sc_pick;     // newest matching entry
  logic [DEPTH-1:0] oldest;
  logic [DEPTH-1:0] ll_free;
  logic [DEPTH-1:0] ins_slot;
  logic [DEPTH-1:0] ins_vec;
  logic             ev_sc_hit;
  logic             ev_evict;
  logic             ev_ll_kill_any;
  logic             ev_wr_fast;

  assign ll_kill        = valid_q & over_v;
  assign other_kill     = valid_q & over_v & ~same_v;
  assign sc_match       = valid_q & same_v & cover_v;
  assign ev_sc_hit      = |sc_match;
  assign ll_free        = ~(valid_q & ~ll_kill);
  assign ev_ll_kill_any = is_ll && (|ll_kill);
  assign ev_evict       = is_ll && !(|ll_free);
  assign ev_wr_fast     = is_wr && (valid_q == '0);
  assign ins_slot       = (|ll_free) ? lowest_one(ll_free) : oldest;
  assign ins_vec        = is_ll ? ins_slot : '0;

  llsc_age_order #(.DEPTH(DEPTH)) u_age (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_vec    (ins_vec),
    .live_vec   (valid_q),
    .pick_mask  (sc_match),
    .oldest_vec (oldest),
    .newest_vec (sc_pick)
  );

  // next state of the valid vector
  logic [DEPTH-1:0] valid_d;
  logic             ok_d;

  always_comb begin
    valid_d = valid_q;
    ok_d    = 1'b1;
    if (is_ll)  valid_d = (valid_q & ~ll_kill) | ins_slot;
    if (is_sc) begin
      valid_d = valid_q & ~(sc_pick | other_kill);
      ok_d    = ev_sc_hit;
    end
    if (is_wr)  valid_d = valid_q & ~other_kill;
    if (is_inv) valid_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      rsp_valid <= req_valid;
      rsp_ok    <= req_valid ? ok_d : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ctx_q[i] <= '0;
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_vec[i]) begin
          ctx_q[i] <= req_ctx;
          lo_q[i]  <= rq_lo;
          hi_q[i]  <= rq_hi;
        end
      end
    end
  end

  // occupancy
  always_comb begin
    resv_count = '0;
    for (int i = 0; i < DEPTH; i++) resv_count = resv_count + CNT_W'(valid_q[i]);
  end
  assign resv_live = |valid_q;

endmodule

// File: rtl/llsc_monitor_checks.sv
module llsc_monitor_checks #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic             resv_live,
  input logic [CNT_W-1:0] resv_count,
  input logic [DEPTH-1:0] sc_pick,
  input logic             ev_evict,
  input logic             ev_ll_kill_any,
  input logic             ev_wr_fast
);
  import llsc_pkg::*;

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r12_ll_ok_live: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == OP_LL) |=> (rsp_ok && resv_live));

  a_r3_ll_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == OP_LL && !ev_ll_kill_any && !ev_evict)
      |=> (resv_count == CNT_W'($past(resv_count) + 1'b1)));

  a_r5_sc_empty_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == OP_SC && resv_count == '0) |=> !rsp_ok);

  a_r6_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sc_pick));

  a_r8_wr_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == OP_WR) |=> rsp_ok);

  a_r8_wr_fast_path: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_fast |=> (resv_count == '0));

  a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == OP_INV) |=> (rsp_ok && resv_count == '0 && !resv_live));

  a_r10_evict_full: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict |=> (resv_count == CNT_W'(DEPTH)));

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    resv_count <= CNT_W'(DEPTH));

  a_r1_live_count: assert property (@(posedge clk) disable iff (!rst_n)
    resv_live == (resv_count != '0));
endmodule

bind llsc_monitor llsc_monitor_checks #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_checks (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_kind       (req_kind),
  .rsp_valid      (rsp_valid),
  .rsp_ok         (rsp_ok),
  .resv_live      (resv_live),
  .resv_count     (resv_count),
  .sc_pick        (sc_pick),
  .ev_evict       (ev_evict),
  .ev_ll_kill_any (ev_ll_kill_any),
  .ev_wr_fast     (ev_wr_fast)
);

// File: tb/llsc_monitor_test.sv
`timescale 1ns/1ps
module llsc_monitor_test;
  import llsc_pkg::*;

  localparam int DEPTH  = 4;
  localparam int CTX_W  = 4;
  localparam int ADDR_W = 16;
  localparam int SIZE_W = 8;
  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int TOPA   = (1 << ADDR_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_kind = 2'd0;
  logic [CTX_W-1:0]  req_ctx = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic              rsp_valid;
  logic              rsp_ok;
  logic              resv_live;
  logic [CNT_W-1:0]  resv_count;

  always #5 clk = ~clk;

  llsc_monitor #(.DEPTH(DEPTH), .CTX_W(CTX_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_ctx(req_ctx), .req_addr(req_addr), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .resv_live(resv_live),
    .resv_count(resv_count)
  );

  int n_checks = 0;
  int n_fails  = 0;

  task automatic check(input bit cond, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural model: index 0 holds the newest reservation
  typedef struct { int ctx; int lo; int hi; } resv_t;
  resv_t model_q[$];

  bit    exp_ok_q[$];
  int    exp_cnt_q[$];
  string exp_tag_q[$];

  function automatic int last_byte(input int a, input int s);
    int n;
    n = (s < 1) ? 1 : s;
    if (a > TOPA - (n - 1)) return TOPA;
    return a + n - 1;
  endfunction

  function automatic bit model_step(input int kind, input int ctx, input int lo, input int hi);
    resv_t keep[$];
    bit    ok;
    bit    found;
    ok = 1'b1;
    keep.delete();
    if (kind == OP_LL) begin
      foreach (model_q[k])
        if (!(lo <= model_q[k].hi && hi >= model_q[k].lo)) keep.push_back(model_q[k]);
      model_q = keep;
      if (model_q.size() == DEPTH) void'(model_q.pop_back());
      model_q.push_front('{ctx, lo, hi});
    end else if (kind == OP_SC) begin
      found = 1'b0;
      foreach (model_q[k]) begin
        if (!found && model_q[k].ctx == ctx && lo >= model_q[k].lo && hi <= model_q[k].hi)
          found = 1'b1;
        else if (!(model_q[k].ctx != ctx && lo <= model_q[k].hi && hi >= model_q[k].lo))
          keep.push_back(model_q[k]);
      end
      model_q = keep;
      ok = found;
    end else if (kind == OP_WR) begin
      foreach (model_q[k])
        if (!(model_q[k].ctx != ctx && lo <= model_q[k].hi && hi >= model_q[k].lo))
          keep.push_back(model_q[k]);
      model_q = keep;
    end else begin
      model_q.delete();
    end
    return ok;
  endfunction

  // driver: computes the expected response and pushes it, then drives one cycle
  task automatic send(input int kind, input int ctx, input int addr, input int size,
                      input string tag);
    bit ok;
    @(negedge clk);
    ok = model_step(kind, ctx, addr, last_byte(addr, size));
    exp_ok_q.push_back(ok);
    exp_cnt_q.push_back(model_q.size());
    exp_tag_q.push_back(tag);
    req_valid = 1'b1;
    req_kind  = kind[1:0];
    req_ctx   = CTX_W'(ctx);
    req_addr  = ADDR_W'(addr);
    req_size  = SIZE_W'(size);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // expected response strobe: the request seen at the last edge
  bit req_seen = 1'b0;
  always @(posedge clk) req_seen <= rst_n && req_valid;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      check(rsp_valid == req_seen, "R2", "rsp_valid timing", rsp_valid, req_seen);
      if (rsp_valid && exp_ok_q.size() > 0) begin
        bit    e_ok;
        int    e_cnt;
        string e_tag;
        e_ok  = exp_ok_q.pop_front();
        e_cnt = exp_cnt_q.pop_front();
        e_tag = exp_tag_q.pop_front();
        check(rsp_ok == e_ok, e_tag, "rsp_ok", rsp_ok, e_ok);
        check(int'(resv_count) == e_cnt, e_tag, "resv_count", resv_count, e_cnt);
        check(resv_live == (e_cnt != 0), "R3", "resv_live", resv_live, e_cnt != 0);
      end
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(resv_live == 1'b0, "R1", "live after reset", resv_live, 0);
    check(resv_count == '0, "R1", "count after reset", resv_count, 0);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);

    // R5 / R8 fast path on empty table
    send(OP_SC, 1, 16'h0010, 4, "R5 sc on empty");
    send(OP_WR, 1, 16'h0010, 4, "R8 write fast path");

    // R12 / R3 record, R5 covered hit, R6 consumed
    send(OP_LL, 1, 16'h0010, 4, "R12 ll ok");
    send(OP_SC, 1, 16'h0011, 2, "R5 sc covered hit");
    send(OP_SC, 1, 16'h0011, 2, "R6 sc repeat fails");
    idle(2);

    // R5 foreign context fails, R7 it kills the foreign reservation
    send(OP_LL, 1, 16'h0010, 4, "R3 ll");
    send(OP_SC, 2, 16'h0010, 4, "R7 foreign sc kills");
    send(OP_SC, 1, 16'h0010, 4, "R7 owner sc after kill");

    // R8 own-context write keeps, foreign overlapping write kills
    send(OP_LL, 1, 16'h0020, 4, "R3 ll");
    send(OP_WR, 1, 16'h0020, 1, "R8 own write keeps");
    send(OP_SC, 1, 16'h0020, 4, "R8 survived own write");
    send(OP_LL, 1, 16'h0020, 4, "R3 ll");
    send(OP_WR, 2, 16'h0023, 2, "R8 foreign write kills");
    send(OP_SC, 1, 16'h0020, 4, "R8 killed by foreign write");

    // R8 disjoint write, R4 overlapping ll from another context
    send(OP_LL, 1, 16'h0030, 4, "R3 ll");
    send(OP_WR, 2, 16'h0034, 4, "R8 disjoint write keeps");
    send(OP_LL, 2, 16'h0032, 4, "R4 ll replaces overlap");
    send(OP_SC, 1, 16'h0030, 1, "R4 displaced reservation");
    send(OP_SC, 2, 16'h0033, 3, "R4 new reservation hit");
    idle(1);

    // R7 same-context partial overlap survives
    send(OP_INV, 0, 0, 1, "R9 invalidate");
    send(OP_LL, 1, 16'h0040, 4, "R3 ll");
    send(OP_SC, 1, 16'h0042, 4, "R7 same ctx partial overlap");
    send(OP_SC, 1, 16'h0040, 4, "R7 partial overlap kept");

    // R10 fill and evict the oldest
    send(OP_LL, 0, 16'h0000, 4, "R10 fill");
    send(OP_LL, 0, 16'h0010, 4, "R10 fill");
    send(OP_LL, 0, 16'h0020, 4, "R10 fill");
    send(OP_LL, 0, 16'h0030, 4, "R10 fill");
    send(OP_LL, 0, 16'h0050, 4, "R10 full evicts");
    send(OP_SC, 0, 16'h0000, 4, "R10 oldest gone");
    send(OP_SC, 0, 16'h0010, 4, "R10 second kept");

    // R11 clamp at top of the address space
    send(OP_INV, 0, 0, 1, "R9 invalidate");
    send(OP_LL, 1, TOPA - 1, 8, "R11 ll at top");
    send(OP_SC, 1, TOPA - 1, 2, "R11 clamped range covers");
    send(OP_LL, 3, TOPA, 0, "R11 size zero as one");
    send(OP_SC, 3, TOPA, 1, "R11 size zero hit");
    send(OP_LL, 2, 16'h0100, 2, "R3 ll");
    send(OP_INV, 2, 0, 1, "R9 invalidate clears");
    idle(2);

    // mixed traffic from three contexts over a narrow window
    for (int i = 0; i < 600; i++) begin
      int r;
      int kind;
      r = $urandom_range(0, 99);
      kind = (r < 40) ? OP_LL : (r < 72) ? OP_SC : (r < 97) ? OP_WR : OP_INV;
      send(kind, $urandom_range(0, 2), $urandom_range(0, 31), $urandom_range(1, 6),
           "mixed R4 R5 R7 R8 R10");
      if ($urandom_range(0, 7) == 0) idle(1);
    end
    idle(3);
    check(exp_ok_q.size() == 0, "R2", "responses outstanding", exp_ok_q.size(), 0);
    summary();
    $finish;
  end
endmodule